// File: doc/BRIEF.md
# Split-Access Microsecond Timebase

This block keeps a 64-bit count of microseconds since reset. An external tick generator supplies a one-cycle enable pulse once per microsecond, and the count advances by one on each such pulse unless the counter is held. Software reaches the count through a 32-bit register bus as two 32-bit halves. Ordered latching keeps each pair of half-accesses coherent.

A write of the lower half is only staged. The later upper-half write loads both halves in the same cycle. Reading the lower half captures the upper half at that moment, so the following upper-half read returns a value that matches the lower half already read. Two raw ports return the live halves with no capture side effect.

The counter can be held by a software pause bit. It can also be held by any debug-halt input whose enable bit is set. A small two-state machine tracks the hold mode:
- State `CNT_RUN`: ticks advance the count.
- State `CNT_HOLD`: ticks are ignored.
- Transition `RUN_TO_HOLD`: taken when a pause condition is seen in a cycle.
- Transition `HOLD_TO_RUN`: taken when no pause condition is seen in a cycle.

The state register follows the pause condition with a delay of one cycle.

Top module: `usec_timebase`

## Requirements
- R1: After reset, the count is zero, the staged lower half and the capture latch are zero, the debug enables are all ones, the pause bit is zero, and read data is zero.
- R2: When a tick is present at a clock edge, the hold state is `CNT_RUN` and no commit occurs, the count increases by exactly one. Without a tick the count is unchanged.
- R3: A write to word offset 0x04 stores the write data as the staged lower half and leaves the count unchanged.
- R4: A write to word offset 0x00 loads the count with the write data in bits 63:32 and the staged lower half in bits 31:0. This commit takes priority over a tick in the same cycle.
- R5: A read of offset 0x0C returns live bits 31:0 and captures live bits 63:32. A read of offset 0x08 returns the captured value. Read data appears on the cycle after the read strobe and holds until the next read.
- R6: A read of offset 0x28 returns live bits 31:0 and a read of offset 0x24 returns live bits 63:32. Neither read changes the capture latch.
- R7: Bit 0 of the register at offset 0x30 is the pause bit. A pause condition present in cycle c puts the block in `CNT_HOLD` after edge c, and a tick at edge c+1 is then ignored.
- R8: Bit i of the register at offset 0x2C enables debug-halt input i. An enabled input that is high forms a pause condition, with the same timing as R7. A disabled input has no effect.
- R9: Writes to offsets 0x08, 0x0C, 0x24, 0x28 and unmapped offsets change nothing. Reads of offsets 0x00, 0x04 and unmapped offsets return zero.
- R10: A tick at count 0xFFFF_FFFF_FFFF_FFFF wraps the count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle microsecond enable pulse |
| halt_i | input | NDBG | Debug-halt requests |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 6 | Byte address; bits 1:0 ignored |
| bus_wdata_i | input | HALF_W | Write data |
| bus_rdata_o | output | HALF_W | Registered read data |
| count_o | output | 2*HALF_W | Live count |

## Verification
The assertions assume that the tick and halt inputs are known after reset and that a read strobe and a write strobe are never high in the same cycle. They also assume the address is meaningful only in bits 5:2. The stimulus drives every input at the falling edge and never raises both strobes together. Besides a fixed set of corner cases, the random phase draws word-aligned addresses from the mapped offsets plus one unmapped offset, and it draws halt patterns and ticks independently.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
    localparam int ADDR_W = 6;
    localparam logic [3:0] W_HI_WR  = 4'd0;
    localparam logic [3:0] W_LO_WR  = 4'd1;
    localparam logic [3:0] W_HI_RD  = 4'd2;
    localparam logic [3:0] W_LO_RD  = 4'd3;
    localparam logic [3:0] W_RAW_HI = 4'd9;
    localparam logic [3:0] W_RAW_LO = 4'd10;
    localparam logic [3:0] W_DBG    = 4'd11;
    localparam logic [3:0] W_PAUSE  = 4'd12;

    typedef enum logic {
        CNT_RUN  = 1'b0,
        CNT_HOLD = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/tmb_regs.sv
module tmb_regs
    import tmb_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int NDBG   = 2,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [HALF_W-1:0] wdata_i,
    input  logic [NDBG-1:0]   halt_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [HALF_W-1:0] rdata_o,
    output logic              commit_o,
    output logic [CNT_W-1:0]  commit_val_o,
    output logic              hold_o
);
    logic [3:0]        widx;
    logic [HALF_W-1:0] stage_q;
    logic [HALF_W-1:0] latch_q;
    logic [NDBG-1:0]   dbg_en_q;
    logic              pause_q;
    logic [HALF_W-1:0] rd_mux;
    logic [HALF_W-1:0] rdata_q;

    assign widx         = addr_i[5:2];
    assign commit_o     = wr_i && (widx == W_HI_WR);
    assign commit_val_o = {wdata_i, stage_q};
    assign hold_o       = pause_q || |(dbg_en_q & halt_i);

    // Register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q  <= '0;
            dbg_en_q <= '1;
            pause_q  <= 1'b0;
        end else if (wr_i) begin
            unique case (widx)
                W_LO_WR: stage_q  <= wdata_i;
                W_DBG:   dbg_en_q <= wdata_i[NDBG-1:0];
                W_PAUSE: pause_q  <= wdata_i[0];
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        unique case (widx)
            W_HI_RD:  rd_mux = latch_q;
            W_LO_RD:  rd_mux = count_i[HALF_W-1:0];
            W_RAW_HI: rd_mux = count_i[CNT_W-1:HALF_W];
            W_RAW_LO: rd_mux = count_i[HALF_W-1:0];
            W_DBG:    rd_mux[NDBG-1:0] = dbg_en_q;
            W_PAUSE:  rd_mux[0] = pause_q;
            default:  rd_mux = '0;
        endcase
    end

    // Read data register and upper-half capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            latch_q <= '0;
        end else if (rd_i) begin
            rdata_q <= rd_mux;
            if (widx == W_LO_RD) begin
                latch_q <= count_i[CNT_W-1:HALF_W];
            end
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/tmb_counter.sv
module tmb_counter
    import tmb_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hold_i,
    input  logic             commit_i,
    input  logic [CNT_W-1:0] commit_val_i,
    output logic [CNT_W-1:0] count_o
);
    cnt_state_e       state_q;
    cnt_state_e       state_d;
    logic             run_en;
    logic [CNT_W-1:0] count_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        run_en  = 1'b0;
        unique case (state_q)
            CNT_RUN: begin
                run_en = 1'b1;
                if (hold_i) state_d = CNT_HOLD;   // RUN_TO_HOLD
            end
            CNT_HOLD: begin
                run_en = 1'b0;
                if (!hold_i) state_d = CNT_RUN;   // HOLD_TO_RUN
            end
            default: state_d = CNT_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (commit_i) begin
            count_q <= commit_val_i;
        end else if (tick_i && run_en) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
    import tmb_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int NDBG   = 2,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NDBG-1:0]   halt_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [HALF_W-1:0] bus_wdata_i,
    output logic [HALF_W-1:0] bus_rdata_o,
    output logic [CNT_W-1:0]  count_o
);
    logic             commit_w;
    logic [CNT_W-1:0] commit_val_w;
    logic             hold_w;

    tmb_regs #(.HALF_W(HALF_W), .NDBG(NDBG)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (bus_wr_i),
        .rd_i         (bus_rd_i),
        .addr_i       (bus_addr_i),
        .wdata_i      (bus_wdata_i),
        .halt_i       (halt_i),
        .count_i      (count_o),
        .rdata_o      (bus_rdata_o),
        .commit_o     (commit_w),
        .commit_val_o (commit_val_w),
        .hold_o       (hold_w)
    );

    tmb_counter #(.CNT_W(CNT_W)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .hold_i       (hold_w),
        .commit_i     (commit_w),
        .commit_val_i (commit_val_w),
        .count_o      (count_o)
    );
endmodule

// File: rtl/tmb_checker.sv
module tmb_checker #(
    parameter int HALF_W = 32,
    localparam int CNT_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [5:0]        bus_addr_i,
    input logic [HALF_W-1:0] bus_wdata_i,
    input logic [HALF_W-1:0] bus_rdata_o,
    input logic [CNT_W-1:0]  count_o,
    input logic              hold_w
);
    logic commit;
    logic hold_prev;
    assign commit = bus_wr_i && (bus_addr_i[5:2] == 4'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_prev <= 1'b0;
        else        hold_prev <= hold_w;
    end

    a_r4_commit_loads_high: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> count_o[CNT_W-1:HALF_W] == $past(bus_wdata_i));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && tick_i && !hold_prev) |=> count_o == $past(count_o) + 1'b1);

    a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && (hold_prev || !tick_i)) |=> $stable(count_o));

    a_r9_write_only_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i[5:3] == 3'd0) |=> bus_rdata_o == '0);

    a_r5_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

bind usec_timebase tmb_checker #(.HALF_W(HALF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .count_o     (count_o),
    .hold_w      (hold_w)
);

// File: tb/test_usec_timebase.sv
`timescale 1ns/1ps
module test_usec_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  halt = 2'b00;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] count;

    int n_tests = 0;
    int n_fail  = 0;

    // Model state
    logic [63:0] m_cnt;
    logic [31:0] m_stage, m_latch, m_rdata;
    logic [1:0]  m_dbg;
    logic        m_pause, m_holdq;

    always #5 clk = ~clk;

    usec_timebase i_usec_timebase (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .halt_i(halt),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .count_o(count)
    );

    function automatic logic [31:0] model_read(logic [3:0] w);
        case (w)
            4'd2:    return m_latch;
            4'd3:    return m_cnt[31:0];
            4'd9:    return m_cnt[63:32];
            4'd10:   return m_cnt[31:0];
            4'd11:   return {30'd0, m_dbg};
            4'd12:   return {31'd0, m_pause};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic tk, logic w, logic r,
                        logic [5:0] a, logic [31:0] d, logic [1:0] h);
        logic        hc;
        logic [3:0]  wi;
        @(negedge clk);
        tick = tk; wr = w; rd = r; addr = a; wdata = d; halt = h;
        @(posedge clk);
        wi = a[5:2];
        hc = m_pause | |(m_dbg & h);
        if (r) begin
            m_rdata = model_read(wi);
            if (wi == 4'd3) m_latch = m_cnt[63:32];
        end
        if (w && wi == 4'd0)     m_cnt = {d, m_stage};
        else if (tk && !m_holdq) m_cnt = m_cnt + 64'd1;
        m_holdq = hc;
        if (w) begin
            if (wi == 4'd1)  m_stage = d;
            if (wi == 4'd11) m_dbg = d[1:0];
            if (wi == 4'd12) m_pause = d[0];
        end
        #1;
        chk({tag, " count"}, count, m_cnt);
        chk({tag, " rdata"}, {32'd0, rdata}, {32'd0, m_rdata});
    endtask

    task automatic rd_reg(string tag, logic [5:0] a);
        step(tag, 1'b0, 1'b0, 1'b1, a, 32'd0, 2'b00);
    endtask

    task automatic wr_reg(string tag, logic [5:0] a, logic [31:0] d);
        step(tag, 1'b0, 1'b1, 1'b0, a, d, 2'b00);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        m_cnt = '0; m_stage = '0; m_latch = '0; m_rdata = '0;
        m_dbg = 2'b11; m_pause = 1'b0; m_holdq = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset count", count, 64'd0);
        chk("R1 reset rdata", {32'd0, rdata}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values of registers
        rd_reg("R1 dbg enables", 6'h2C);
        rd_reg("R1 pause", 6'h30);
        rd_reg("R1 latch", 6'h08);

        // R2: counting
        for (int i = 0; i < 5; i++) step("R2 tick", 1'b1, 1'b0, 1'b0, 6'h3C, 32'd0, 2'b00);
        step("R2 no tick", 1'b0, 1'b0, 1'b0, 6'h3C, 32'd0, 2'b00);

        // R3: staged low write
        step("R3 stage", 1'b0, 1'b1, 1'b0, 6'h04, 32'hFFFF_FFFF, 2'b00);
        // R4: commit with simultaneous tick
        step("R4 commit", 1'b1, 1'b1, 1'b0, 6'h00, 32'h0000_0000, 2'b00);
        // R5: low read captures high; carry between reads
        rd_reg("R5 low read", 6'h0C);
        step("R5 carry", 1'b1, 1'b0, 1'b0, 6'h3C, 32'd0, 2'b00);
        rd_reg("R5 latched high", 6'h08);
        // R6: raw reads show live value, latch unchanged
        rd_reg("R6 raw high", 6'h24);
        rd_reg("R6 raw low", 6'h28);
        rd_reg("R6 latch kept", 6'h08);

        // R10: wrap
        wr_reg("R10 stage", 6'h04, 32'hFFFF_FFFF);
        wr_reg("R10 commit", 6'h00, 32'hFFFF_FFFF);
        step("R10 wrap", 1'b1, 1'b0, 1'b0, 6'h3C, 32'd0, 2'b00);

        // R7: pause bit
        wr_reg("R7 set pause", 6'h30, 32'd1);
        for (int i = 0; i < 4; i++) step("R7 paused", 1'b1, 1'b0, 1'b0, 6'h3C, 32'd0, 2'b00);
        wr_reg("R7 clear pause", 6'h30, 32'd0);
        for (int i = 0; i < 3; i++) step("R7 resume", 1'b1, 1'b0, 1'b0, 6'h3C, 32'd0, 2'b00);

        // R8: debug halt, enabled and disabled
        for (int i = 0; i < 3; i++) step("R8 halt en", 1'b1, 1'b0, 1'b0, 6'h3C, 32'd0, 2'b01);
        wr_reg("R8 disable port0", 6'h2C, 32'd2);
        for (int i = 0; i < 3; i++) step("R8 halt dis", 1'b1, 1'b0, 1'b0, 6'h3C, 32'd0, 2'b01);
        for (int i = 0; i < 3; i++) step("R8 halt port1", 1'b1, 1'b0, 1'b0, 6'h3C, 32'd0, 2'b10);
        rd_reg("R8 dbg readback", 6'h2C);

        // R9: ignored writes and zero reads
        wr_reg("R9 wr hi rd", 6'h08, 32'h1234_5678);
        wr_reg("R9 wr raw lo", 6'h28, 32'h1234_5678);
        wr_reg("R9 wr unmapped", 6'h14, 32'h1234_5678);
        rd_reg("R9 rd hi wr", 6'h00);
        rd_reg("R9 rd lo wr", 6'h04);
        rd_reg("R9 rd unmapped", 6'h14);
        rd_reg("R9 rd latch after wr", 6'h08);

        // Random phase
        begin
            logic [5:0] amap [9] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h24,
                                     6'h28, 6'h2C, 6'h30, 6'h18};
            int          seed = $urandom(1234);
            logic [31:0] d;
            int          op;
            for (int i = 0; i < 3000; i++) begin
                op = int'($urandom_range(0, 9));
                d  = $urandom();
                if (amap[op % 9] == 6'h30 && ($urandom_range(0, 3) != 0)) d[0] = 1'b0;
                if (op < 3)
                    step("R2 random write", $urandom_range(0, 1) == 1, 1'b1, 1'b0,
                         amap[$urandom_range(0, 8)], d, 2'($urandom_range(0, 3)));
                else if (op < 6)
                    step("R5 random read", $urandom_range(0, 1) == 1, 1'b0, 1'b1,
                         amap[$urandom_range(0, 8)], d, 2'($urandom_range(0, 3)));
                else
                    step("R2 random idle", $urandom_range(0, 3) != 0, 1'b0, 1'b0,
                         6'h3C, d, ($urandom_range(0, 7) == 0) ? 2'b11 : 2'b00);
                if (seed < 0) seed = 0;
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule